// File: doc/BRIEF.md
# Multi-Source Digital Input Interrupt Controller

This block watches a bank of parallel digital input lines and folds several kinds of events into one interrupt request line. Each of four line groups offers two candidate lines, bit 0 and bit 4 of the group's byte. A two-bit source selector in the group's control byte chooses which of those lines may raise an event. A polarity bit chooses whether the rising or the falling edge counts.

Two further detectors watch a pair of dedicated byte inputs. A masked comparator raises an event when every selected line of the first byte takes its preset level. A change detector raises an event whenever any line of the second byte changes. Each of the six sources owns a sticky pending flag, so several requests can wait at once. Software reads the flags over a small byte-wide register bus and clears them by writing ones.

All watched inputs pass through two flip-flops before any edge or change is judged. The interrupt output is the OR of the pending flags whose source is currently enabled. Register access is a plain single-cycle write strobe with a combinational read, so the block has no stream interface and no back-pressure.

Top module: `dio_irq_unit`

## Requirements
- R1: After reset all control, preset, mask, enable and pending registers read 0 and `irq` is 0.
- R2: Control byte of group g sits at address g (0..3); bits [1:0] choose the source: 00 none, 01 line bit 0, 10 line bit 4, 11 both lines.
- R3: Control bit 2 picks the polarity: 0 means a rising edge of a selected line sets the group's pending flag, 1 means a falling edge; the other edge and changes on unselected lines have no effect.
- R4: A group whose source field is 00 never sets its pending flag, whatever its lines do.
- R5: With the match detector enabled, pending bit 4 is set when the bits of `pat_in` chosen by the mask (address 5) all equal the preset byte (address 4); unmasked bits are ignored.
- R6: The match detector fires only on entry into the matching condition; it does not set the flag again while the match persists.
- R7: With the change detector enabled, any change of any bit of `cos_in` sets pending bit 5.
- R8: The enable byte (address 6) has bit 0 for the match detector and bit 1 for the change detector; while a bit is 0 its detector never sets its pending flag.
- R9: The pending byte (address 7) holds group flags in bits 0..3, match in bit 4, change in bit 5; writing 1 to a bit clears it, writing 0 leaves it unchanged.
- R10: If a clear and a new event for the same flag land in the same cycle, the flag ends up set.
- R11: `irq` is 1 exactly when some pending flag is set whose source is enabled (group source field nonzero, or the detector's enable bit); a set flag of a disabled source stays readable but does not drive `irq`.
- R12: An input change applied before clock edge k is synchronised by two stages and shows in the pending byte after edge k+2, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| grp_in | input | 32 | Four group bytes, group g in bits [8g+7:8g] |
| pat_in | input | 8 | Byte watched by the match detector |
| cos_in | input | 8 | Byte watched by the change detector |
| irq | output | 1 | Shared interrupt request |

## Verification
The pending register is written by two functions that can meet in one cycle: a software clear of a flag and a fresh event that sets the same flag. The bench moves a group line and times a clear write so that it is sampled on the very edge at which the synchronised edge reaches the pending register, two edges after the input change; the flag must read set afterwards. A clear issued one cycle later must then empty the flag, which shows that the earlier survival came from the set winning and not from a dead clear path.

// File: rtl/dio_irq_pkg.sv
package dio_irq_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_LOW  = 2'b01,
    SRC_HIGH = 2'b10,
    SRC_BOTH = 2'b11
  } src_sel_e;

  // one-cycle edge of a synchronised line in the chosen direction
  function automatic logic edge_seen(input logic cur, input logic prev, input logic falling);
    return falling ? (prev & ~cur) : (cur & ~prev);
  endfunction
endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta_q, stab_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
      last_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
      last_q <= stab_q;
    end
  end

  assign cur  = stab_q;
  assign prev = last_q;
endmodule

// File: rtl/dio_grp_src.sv
module dio_grp_src
  import dio_irq_pkg::*;
(
  input  logic [1:0] line_cur,   // [0] = byte bit 0, [1] = byte bit 4
  input  logic [1:0] line_prev,
  input  logic [1:0] sel,
  input  logic       falling,
  output logic       hit
);
  src_sel_e mode;
  logic     e_lo, e_hi;

  always_comb begin
    mode = src_sel_e'(sel);
    e_lo = edge_seen(line_cur[0], line_prev[0], falling);
    e_hi = edge_seen(line_cur[1], line_prev[1], falling);
    unique case (mode)
      SRC_NONE: hit = 1'b0;
      SRC_LOW:  hit = e_lo;
      SRC_HIGH: hit = e_hi;
      SRC_BOTH: hit = e_lo | e_hi;
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/dio_pat_cos.sv
module dio_pat_cos #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pat_cur,
  input  logic [W-1:0] preset,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] cos_cur,
  input  logic [W-1:0] cos_prev,
  output logic         pat_hit,
  output logic         cos_hit
);
  logic match_now, match_q;

  assign match_now = (((pat_cur ^ preset) & mask) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= match_now;
  end

  assign pat_hit = match_now & ~match_q;
  assign cos_hit = (cos_cur != cos_prev);
endmodule

// File: rtl/dio_irq_unit.sv
module dio_irq_unit
  import dio_irq_pkg::*;
#(
  parameter int NUM_GRP = 4,
  parameter int AW      = $clog2(NUM_GRP + 4)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [AW-1:0]             bus_addr,
  input  logic                      bus_wr,
  input  logic [BYTE_W-1:0]         bus_wdata,
  output logic [BYTE_W-1:0]         bus_rdata,
  input  logic [NUM_GRP*BYTE_W-1:0] grp_in,
  input  logic [BYTE_W-1:0]         pat_in,
  input  logic [BYTE_W-1:0]         cos_in,
  output logic                      irq
);
  localparam int PW       = NUM_GRP + 2;
  localparam int HI_BIT   = BYTE_W / 2;
  localparam int A_PVAL   = NUM_GRP;
  localparam int A_PMSK   = NUM_GRP + 1;
  localparam int A_ENA    = NUM_GRP + 2;
  localparam int A_PEND   = NUM_GRP + 3;
  localparam int PAT_BIT  = NUM_GRP;
  localparam int COS_BIT  = NUM_GRP + 1;

  logic [2:0]          ctrl_q [NUM_GRP];
  logic [BYTE_W-1:0]   pval_q, pmsk_q;
  logic [1:0]          ena_q;
  logic [PW-1:0]       pend_q;
  logic [PW-1:0]       hit, en_vec, clr;

  logic [2*NUM_GRP-1:0] line_raw, line_cur, line_prev;
  logic [BYTE_W-1:0]    pat_cur, pat_prev_unused, cos_cur, cos_prev;

  genvar g;
  generate
    for (g = 0; g < NUM_GRP; g++) begin : g_grp
      assign line_raw[2*g]   = grp_in[g*BYTE_W];
      assign line_raw[2*g+1] = grp_in[g*BYTE_W + HI_BIT];

      dio_grp_src u_src (
        .line_cur  (line_cur[2*g+1 -: 2]),
        .line_prev (line_prev[2*g+1 -: 2]),
        .sel       (ctrl_q[g][1:0]),
        .falling   (ctrl_q[g][2]),
        .hit       (hit[g])
      );
      assign en_vec[g] = (ctrl_q[g][1:0] != 2'b00);
    end
  endgenerate

  dio_sync #(.W(2*NUM_GRP)) u_sync_grp (
    .clk(clk), .rst_n(rst_n), .d(line_raw), .cur(line_cur), .prev(line_prev));
  dio_sync #(.W(BYTE_W)) u_sync_pat (
    .clk(clk), .rst_n(rst_n), .d(pat_in), .cur(pat_cur), .prev(pat_prev_unused));
  dio_sync #(.W(BYTE_W)) u_sync_cos (
    .clk(clk), .rst_n(rst_n), .d(cos_in), .cur(cos_cur), .prev(cos_prev));

  dio_pat_cos #(.W(BYTE_W)) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .pat_cur  (pat_cur),
    .preset   (pval_q),
    .mask     (pmsk_q),
    .cos_cur  (cos_cur),
    .cos_prev (cos_prev),
    .pat_hit  (hit[PAT_BIT]),
    .cos_hit  (hit[COS_BIT])
  );

  assign en_vec[PAT_BIT] = ena_q[0];
  assign en_vec[COS_BIT] = ena_q[1];

  assign clr = (bus_wr && bus_addr == AW'(A_PEND)) ? bus_wdata[PW-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_GRP; i++) ctrl_q[i] <= '0;
      pval_q <= '0;
      pmsk_q <= '0;
      ena_q  <= '0;
      pend_q <= '0;
    end else begin
      if (bus_wr) begin
        for (int i = 0; i < NUM_GRP; i++)
          if (bus_addr == AW'(i)) ctrl_q[i] <= bus_wdata[2:0];
        if (bus_addr == AW'(A_PVAL)) pval_q <= bus_wdata;
        if (bus_addr == AW'(A_PMSK)) pmsk_q <= bus_wdata;
        if (bus_addr == AW'(A_ENA))  ena_q  <= bus_wdata[1:0];
      end
      // a new event outranks a clear of the same flag
      pend_q <= (pend_q & ~clr) | (hit & en_vec);
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_GRP; i++)
      if (bus_addr == AW'(i)) bus_rdata = BYTE_W'(ctrl_q[i]);
    if (bus_addr == AW'(A_PVAL)) bus_rdata = pval_q;
    if (bus_addr == AW'(A_PMSK)) bus_rdata = pmsk_q;
    if (bus_addr == AW'(A_ENA))  bus_rdata = BYTE_W'(ena_q);
    if (bus_addr == AW'(A_PEND)) bus_rdata = BYTE_W'(pend_q);
  end

  assign irq = |(pend_q & en_vec);
endmodule

// File: rtl/dio_irq_chk.sv
module dio_irq_chk #(
  parameter int PW   = 6,
  parameter int AW   = 3,
  parameter int PEND = 7,
  parameter int W    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [W-1:0]  bus_wdata,
  input logic          irq,
  input logic [PW-1:0] pend,
  input logic [1:0]    ena,
  input logic [W-1:0]  cos_cur,
  input logic [W-1:0]  cos_prev
);
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pend) & ~(($past(bus_wr) && $past(bus_addr) == AW'(PEND)) ? $past(bus_wdata[PW-1:0]) : '0)
      & ~pend) == '0)); // R9

  AST_PAT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[PW-2]) |-> $past(ena[0])); // R8

  AST_COS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[PW-1]) |-> ($past(cos_cur != cos_prev) && $past(ena[1]))); // R7

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> !irq); // R11
endmodule

bind dio_irq_unit dio_irq_chk #(
  .PW(NUM_GRP + 2), .AW(AW), .PEND(NUM_GRP + 3), .W(dio_irq_pkg::BYTE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq       (irq),
  .pend      (pend_q),
  .ena       (ena_q),
  .cos_cur   (cos_cur),
  .cos_prev  (cos_prev)
);

// File: tb/dio_irq_unit_tb.sv
module dio_irq_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [31:0] grp_in = '0;
  logic [7:0]  pat_in = '0;
  logic [7:0]  cos_in = '0;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;
  logic [7:0]  rv;

  always #2 clk = ~clk;

  dio_irq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .grp_in(grp_in),
    .pat_in(pat_in), .cos_in(cos_in), .irq(irq));

  // {group, source field, falling, expected flag, start byte, end byte}
  localparam logic [21:0] VEC [10] = '{
    {2'd0, 2'b01, 1'b0, 1'b1, 8'h00, 8'h01},
    {2'd0, 2'b01, 1'b0, 1'b0, 8'h00, 8'h10},
    {2'd1, 2'b10, 1'b0, 1'b1, 8'h00, 8'h10},
    {2'd1, 2'b10, 1'b0, 1'b0, 8'h00, 8'h01},
    {2'd2, 2'b11, 1'b1, 1'b1, 8'h11, 8'h01},
    {2'd2, 2'b11, 1'b0, 1'b0, 8'h11, 8'h01},
    {2'd3, 2'b00, 1'b0, 1'b0, 8'h00, 8'h11},
    {2'd3, 2'b11, 1'b1, 1'b1, 8'h01, 8'h00},
    {2'd0, 2'b01, 1'b1, 1'b0, 8'h00, 8'h01},
    {2'd1, 2'b11, 1'b0, 1'b0, 8'h00, 8'hEE}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), rv);
      check("R1 register reset", rv, 8'h00);
    end
    check("R1 irq reset", {7'b0, irq}, 8'h00);

    // R2 R3 R4: table of group source cases
    for (int i = 0; i < 10; i++) begin
      logic [1:0] g; logic [1:0] m; logic f; logic e; logic [7:0] b0, b1;
      {g, m, f, e, b0, b1} = VEC[i];
      wr(3'(g), {5'b0, f, m});
      grp_in[g*8 +: 8] = b0;
      settle();
      wr(3'd7, 8'h3F);
      grp_in[g*8 +: 8] = b1;
      settle();
      rd(3'd7, rv);
      check("R2/R3/R4 group vector", rv, e ? (8'h01 << g) : 8'h00);
      wr(3'(g), 8'h00);
      grp_in = '0;
      settle();
      wr(3'd7, 8'h3F);
    end

    // R12: two-stage latency, then R11 gating and R9 clearing
    wr(3'd0, 8'h01);
    @(negedge clk);
    grp_in[0] = 1'b1;
    repeat (2) @(negedge clk);
    rd(3'd7, rv);
    check("R12 not before third edge", rv, 8'h00);
    @(negedge clk);
    rd(3'd7, rv);
    check("R12 set after third edge", rv, 8'h01);
    check("R11 irq with enabled flag", {7'b0, irq}, 8'h01);
    wr(3'd0, 8'h00);
    rd(3'd7, rv);
    check("R11 flag kept while disabled", rv, 8'h01);
    check("R11 irq hidden when disabled", {7'b0, irq}, 8'h00);
    wr(3'd0, 8'h01);
    wr(3'd7, 8'h00);
    rd(3'd7, rv);
    check("R9 write of zero keeps flag", rv, 8'h01);
    wr(3'd7, 8'h01);
    rd(3'd7, rv);
    check("R9 write of one clears", rv, 8'h00);
    check("R11 irq low after clear", {7'b0, irq}, 8'h00);

    // R10: clear and new event in the same cycle
    grp_in[0] = 1'b0;
    settle();
    wr(3'd7, 8'h3F);
    @(negedge clk);
    grp_in[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_addr = 3'd7; bus_wdata = 8'h01; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(3'd7, rv);
    check("R10 set wins over clear", rv, 8'h01);
    wr(3'd7, 8'h01);
    rd(3'd7, rv);
    check("R10 later clear empties", rv, 8'h00);
    wr(3'd0, 8'h00);
    grp_in = '0;
    settle();
    wr(3'd7, 8'h3F);

    // R5 R6: masked match detector; care bits 7,6,1,0 must be 1,0,1,0
    wr(3'd4, 8'h82);
    wr(3'd5, 8'hC3);
    wr(3'd6, 8'h01);
    settle();
    wr(3'd7, 8'h3F);
    pat_in = 8'h82;
    settle();
    rd(3'd7, rv);
    check("R5 match sets bit 4", rv, 8'h10);
    check("R11 irq from match", {7'b0, irq}, 8'h01);
    wr(3'd7, 8'h10);
    pat_in = 8'hBE;
    settle();
    rd(3'd7, rv);
    check("R6 no refire, R5 unmasked ignored", rv, 8'h00);
    pat_in = 8'h83;
    settle();
    pat_in = 8'hC2;
    settle();
    rd(3'd7, rv);
    check("R5 mismatch on care bit", rv, 8'h00);
    pat_in = 8'h82;
    settle();
    rd(3'd7, rv);
    check("R6 fires again on re-entry", rv, 8'h10);
    wr(3'd6, 8'h00);
    wr(3'd7, 8'h3F);
    pat_in = 8'h00;
    settle();
    pat_in = 8'h82;
    settle();
    rd(3'd7, rv);
    check("R8 match disabled", rv, 8'h00);

    // R7 R8: change detector
    wr(3'd6, 8'h02);
    wr(3'd7, 8'h3F);
    cos_in = 8'h40;
    settle();
    rd(3'd7, rv);
    check("R7 change sets bit 5", rv, 8'h20);
    wr(3'd7, 8'h20);
    settle();
    rd(3'd7, rv);
    check("R7 steady input no flag", rv, 8'h00);
    cos_in = 8'h41;
    settle();
    rd(3'd7, rv);
    check("R7 single-bit change", rv, 8'h20);
    wr(3'd6, 8'h00);
    wr(3'd7, 8'h3F);
    cos_in = 8'h00;
    settle();
    rd(3'd7, rv);
    check("R8 change disabled", rv, 8'h00);
    check("R11 irq idle", {7'b0, irq}, 8'h00);

    finish_run();
  end
endmodule